// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog that sits on a simple 32-bit register bus. Software commits one control word after reset. That word sets a 16-bit timeout, turns the watchdog on or leaves it off, picks the expiry action and chooses whether the tick comes from an optional prescaler. Once the watchdog is running, a down-counter moves one step per tick. Software keeps it from expiring by writing two fixed 16-bit keys, in order, to a service register. A completed pair reloads the counter from the timeout field.

When the counter runs out, the block does one of two things. It sends a single-cycle pulse toward the system reset controller, or it raises a sticky interrupt level. The interrupt stays high until the next valid key pair. Because the control word can be committed only once, a faulty program cannot stop a running watchdog, and it cannot start one that was left off.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset, the control register reads 0xFFFF0003 (timeout 0xFFFF, off, reset action, prescale on). The count register reads 0x0000FFFF. Both outputs are low.
- R2: The control register is at byte address 0x04. It holds the timeout in bits 31:16, the enable in bit 2, the action select in bit 1 (1 = reset, 0 = interrupt) and the prescale enable in bit 0. All other bits read as zero. The count register is at 0x08, and the service register is at 0x0E with its key in write-data bits 15:0. Reads from any other address, and from 0x0E, return zero.
- R3: Only the first control write after reset takes effect. It loads the counter from the new timeout when the enable bit is set. Every later control write leaves the control register unchanged.
- R4: A first control write with the enable bit at 0 locks the block off. After that, the counter holds its value whatever control or service writes follow.
- R5: While the watchdog runs, the counter drops by one every clock when prescale is off. When prescale is on, it drops by one every 2^PRE_LOG2 clocks. The prescaler restarts on each commit and each reload.
- R6: A service write of 0x556C followed directly by a service write of 0xAA39 reloads the counter from the timeout on the second write's clock edge.
- R7: A service write that is not the expected next key returns the key checker to waiting for 0x556C. This holds for a repeated 0x556C, and it means a 0xAA39 without a directly preceding 0x556C does not reload the counter.
- R8: When the action select is 1, the tick that takes the counter to zero raises the reset output for exactly one cycle. The counter then stays at zero.
- R9: When the action select is 0, that same tick raises the interrupt output. The interrupt stays high until a valid key pair clears it, and that pair also reloads the counter.
- R10: A read of the count register returns the counter in bits 15:0 and zeros in bits 31:16. Writes to the count register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| wdt_rst_pulse | output | 1 | One-cycle expiry pulse (reset action) |
| wdt_irq | output | 1 | Sticky expiry level (interrupt action) |

## Verification
The bench builds the block with PRE_LOG2 set to 3, so a prescaled tick comes every 8 clocks. This puts the prescaled count rate, and the way the prescaler restarts after a reload, within a few dozen cycles. The keys and the reset timeout keep their default values. The default 0xFFFF timeout is therefore seen only as a counter that stays still while the block is off. Expiry is reached with short committed timeouts of 3 and 5 ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned CNT_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0] timeout;
    logic             en;
    logic             sel_rst;
    logic             pre_en;
  } wd_ctrl_t;

  localparam wd_ctrl_t CTRL_RST = '{timeout: 16'hFFFF, en: 1'b0, sel_rst: 1'b1, pre_en: 1'b1};

  // Register word layout: timeout in 31:16, enable 2, action select 1, prescale 0.
  function automatic logic [31:0] ctrl_to_word(wd_ctrl_t c);
    return {c.timeout, 13'd0, c.en, c.sel_rst, c.pre_en};
  endfunction

  function automatic wd_ctrl_t word_to_ctrl(logic [31:0] w);
    wd_ctrl_t c;
    c.timeout = w[31:16];
    c.en      = w[2];
    c.sel_rst = w[1];
    c.pre_en  = w[0];
    return c;
  endfunction

  // One counter step: decrement on a tick, never below zero.
  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] c, logic tick);
    return (tick && c != '0) ? c - 1'b1 : c;
  endfunction

  // The tick that brings the counter to zero (or finds it there) expires it.
  function automatic logic is_last_tick(logic [CNT_W-1:0] c);
    return c <= 1;
  endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output wd_ctrl_t    ctrl_q,
  output logic        locked_q,
  output logic        commit_evt
);

  assign commit_evt = wr_ctrl && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      locked_q <= 1'b0;
    end else if (commit_evt) begin
      ctrl_q   <= word_to_ctrl(wdata);
      locked_q <= 1'b1;
    end
  end

  // R3: once committed, the control word never moves again
  a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |-> $stable(ctrl_q));

  // R3: the lock never releases while out of reset
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

endmodule

// File: rtl/wdog_key_check.sv
module wdog_key_check #(
  parameter logic [15:0] KEY_FIRST  = 16'h556C,
  parameter logic [15:0] KEY_SECOND = 16'hAA39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_svc,
  input  logic [15:0] svc_data,
  output logic        service_evt
);

  logic armed_q;

  assign service_evt = wr_svc && armed_q && (svc_data == KEY_SECOND);

  // Any service write re-decides the state: only a first key arms,
  // everything else (including the completing key) disarms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_svc) armed_q <= !armed_q && (svc_data == KEY_FIRST);
  end

  // R7: the checker arms only on a write of the first key
  a_r7_arm_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(wr_svc) && $past(svc_data) == KEY_FIRST));

  // R7: a service write while armed always leaves the armed state
  a_r7_disarm_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && armed_q) |=> !armed_q);

endmodule

// File: rtl/wdog_tick_count.sv
module wdog_tick_count
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic             sel_rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             rst_pulse_q,
  output logic             irq_q,
  output logic             expire_evt
);

  logic tick;
  logic fired_q;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pre_q <= '0;
        else if (load || !run) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end
      assign tick = run && (!pre_en || (&pre_q));
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  assign expire_evt = tick && !load && !fired_q && is_last_tick(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CTRL_RST.timeout;
      fired_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      cnt_q   <= count_step(cnt_q, tick);
      if (expire_evt) fired_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      rst_pulse_q <= expire_evt && sel_rst;
      if (irq_clr)                    irq_q <= 1'b0;
      else if (expire_evt && !sel_rst) irq_q <= 1'b1;
    end
  end

  // R5: without a reload the counter moves by at most one step per clock
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q == $past(cnt_q) || cnt_q == ($past(cnt_q) - 16'd1)));

  // R8: the reset output is never high two cycles running
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_q |=> !rst_pulse_q);

  // R9: the interrupt holds until a valid service clears it
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);

  // R8: after an expiry the counter rests at zero
  a_r8_zero_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> cnt_q == '0);

endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_LOG2   = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [15:0] KEY_FIRST  = 16'h556C,
  parameter logic [15:0] KEY_SECOND = 16'hAA39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_pulse,
  output logic              wdt_irq
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_SVC  = ADDR_W'(8'h0E);

  wd_ctrl_t         ctrl;
  logic             locked;
  logic             commit_evt;
  logic             service_evt;
  logic             expire_evt;
  logic             run;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             wr_ctrl;
  logic             wr_svc;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
  assign wr_svc  = bus_sel && bus_wr && (bus_addr == OFF_SVC);
  assign run     = locked && ctrl.en;

  // Commit with enable loads the fresh timeout; a service reloads only while running.
  assign load     = (commit_evt && bus_wdata[2]) || (service_evt && run);
  assign load_val = commit_evt ? bus_wdata[31:16] : ctrl.timeout;

  wdog_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wdata      (bus_wdata),
    .ctrl_q     (ctrl),
    .locked_q   (locked),
    .commit_evt (commit_evt)
  );

  wdog_key_check #(
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_keys (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_svc      (wr_svc),
    .svc_data    (bus_wdata[15:0]),
    .service_evt (service_evt)
  );

  wdog_tick_count #(
    .PRE_LOG2 (PRE_LOG2)
  ) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .pre_en      (ctrl.pre_en),
    .sel_rst     (ctrl.sel_rst),
    .load        (load),
    .load_val    (load_val),
    .irq_clr     (service_evt),
    .cnt_q       (cnt),
    .rst_pulse_q (wdt_rst_pulse),
    .irq_q       (wdt_irq),
    .expire_evt  (expire_evt)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == OFF_CTRL)     bus_rdata = ctrl_to_word(ctrl);
      else if (bus_addr == OFF_CNT) bus_rdata = {16'd0, cnt};
    end
  end

  // R4: a block locked off keeps its counter frozen
  a_r4_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !ctrl.en) |=> $stable(cnt));

  // R6: a completed key pair on a running block reloads the timeout
  a_r6_service_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (service_evt && run) |=> cnt == ctrl.timeout);

  // R8: only the reset action produces a pulse, only the interrupt action a rising level
  a_r8_pulse_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_pulse) |-> $past(ctrl.sel_rst));

  // R9: the interrupt only rises on an expiry with the interrupt action
  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> ($past(expire_evt) && !$past(ctrl.sel_rst)));

endmodule

// File: tb/wdog_keyed_top_tb.sv
module wdog_keyed_top_tb_top;

  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h08;
  localparam logic [7:0] A_SVC  = 8'h0E;
  localparam logic [31:0] K1 = 32'h0000_556C;
  localparam logic [31:0] K2 = 32'h0000_AA39;

  typedef struct packed {
    logic [15:0] tmo;
    logic        pre;
    logic [15:0] wait_n;
    logic [15:0] exp_cnt;
  } vec_t;

  // Prescale ratio in this bench is 8: expected = tmo - (pre ? wait/8 : wait)
  localparam vec_t VECS [0:4] = '{
    '{16'd100,    1'b0, 16'd10, 16'd90},
    '{16'h0040,   1'b1, 16'd20, 16'h003E},
    '{16'hFFFF,   1'b0, 16'd1,  16'hFFFE},
    '{16'd5,      1'b1, 16'd7,  16'd5},
    '{16'd300,    1'b0, 16'd0,  16'd300}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_pulse;
  logic        wdt_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_keyed_top #(.PRE_LOG2(3)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .wdt_rst_pulse (wdt_rst_pulse),
    .wdt_irq       (wdt_irq)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_edges(2);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk);

    // Table walk: commit, wait, read count (R5, R3)
    for (int i = 0; i < 5; i++) begin
      do_reset();
      bus_write(A_CTRL, {VECS[i].tmo, 13'd0, 1'b1, 1'b1, VECS[i].pre});
      wait_edges(int'(VECS[i].wait_n));
      bus_read(A_CNT, rd);
      check_eq("R5 table count", rd, {16'd0, VECS[i].exp_cnt});
    end

    // R1 reset state
    do_reset();
    bus_read(A_CTRL, rd);  check_eq("R1 ctrl reset", rd, 32'hFFFF_0003);
    bus_read(A_CNT, rd);   check_eq("R1 count reset", rd, 32'h0000_FFFF);
    check_eq("R1 outputs low", {30'd0, wdt_rst_pulse, wdt_irq}, 32'd0);
    bus_read(8'h0C, rd);   check_eq("R2 unmapped read", rd, 32'd0);
    wait_edges(20);
    bus_read(A_CNT, rd);   check_eq("R1 idle count", rd, 32'h0000_FFFF);

    // R2/R3 commit and lock
    do_reset();
    bus_write(A_CTRL, 32'h0032_0006);
    bus_read(A_CTRL, rd);  check_eq("R2 ctrl layout", rd, 32'h0032_0006);
    bus_write(A_CTRL, 32'h000A_0001);
    bus_read(A_CTRL, rd);  check_eq("R3 second write ignored", rd, 32'h0032_0006);
    bus_read(A_CNT, rd);   check_eq("R3 still running", rd, 32'd49);
    // R10 count write ignored
    bus_write(A_CNT, 32'hFFFF_1234);
    bus_read(A_CNT, rd);   check_eq("R10 count write ignored", rd, 32'd48);
    // R7 lone second key
    bus_write(A_SVC, K2);
    bus_read(A_CNT, rd);   check_eq("R7 lone key no reload", rd, 32'd47);
    bus_write(A_SVC, K1); bus_write(A_SVC, 32'h1234); bus_write(A_SVC, K2);
    bus_read(A_CNT, rd);   check_eq("R7 broken pair", rd, 32'd44);
    bus_write(A_SVC, K1); bus_write(A_SVC, K1); bus_write(A_SVC, K2);
    bus_read(A_CNT, rd);   check_eq("R7 repeated first key", rd, 32'd41);
    // R6 valid pair
    bus_write(A_SVC, K1); bus_write(A_SVC, K2);
    bus_read(A_CNT, rd);   check_eq("R6 reload", rd, 32'd50);
    wait_edges(10);
    bus_read(A_CNT, rd);   check_eq("R5 unscaled rate", rd, 32'd40);

    // R4 locked off
    do_reset();
    bus_write(A_CTRL, 32'h0010_0002);
    bus_write(A_CTRL, 32'h0010_0006);
    wait_edges(20);
    bus_read(A_CNT, rd);   check_eq("R4 count frozen", rd, 32'h0000_FFFF);
    bus_read(A_CTRL, rd);  check_eq("R4 stays off", rd, 32'h0010_0002);
    bus_write(A_SVC, K1); bus_write(A_SVC, K2);
    bus_read(A_CNT, rd);   check_eq("R4 service no load", rd, 32'h0000_FFFF);

    // R8 reset action
    do_reset();
    bus_write(A_CTRL, 32'h0005_0006);
    wait_edges(4);
    bus_read(A_CNT, rd);   check_eq("R8 count before expiry", rd, 32'd1);
    check_eq("R8 no early pulse", {31'd0, wdt_rst_pulse}, 32'd0);
    wait_edges(1);
    check_eq("R8 pulse high", {31'd0, wdt_rst_pulse}, 32'd1);
    bus_read(A_CNT, rd);   check_eq("R8 count zero", rd, 32'd0);
    wait_edges(1);
    check_eq("R8 pulse one cycle", {31'd0, wdt_rst_pulse}, 32'd0);
    wait_edges(10);
    check_eq("R8 quiet after", {30'd0, wdt_rst_pulse, wdt_irq}, 32'd0);
    bus_read(A_CNT, rd);   check_eq("R8 holds zero", rd, 32'd0);

    // R9 interrupt action
    do_reset();
    bus_write(A_CTRL, 32'h0003_0004);
    wait_edges(3);
    check_eq("R9 irq raised", {30'd0, wdt_rst_pulse, wdt_irq}, 32'd1);
    wait_edges(5);
    check_eq("R9 irq sticky", {31'd0, wdt_irq}, 32'd1);
    bus_write(A_SVC, K2);
    check_eq("R7 lone key keeps irq", {31'd0, wdt_irq}, 32'd1);
    bus_write(A_SVC, K1); bus_write(A_SVC, K2);
    check_eq("R9 irq cleared", {31'd0, wdt_irq}, 32'd0);
    bus_read(A_CNT, rd);   check_eq("R9 reload on clear", rd, 32'd3);

    // R5 prescaler restart on reload
    do_reset();
    bus_write(A_CTRL, 32'h0004_0005);
    wait_edges(12);
    bus_read(A_CNT, rd);   check_eq("R5 prescaled", rd, 32'd3);
    bus_write(A_SVC, K1); bus_write(A_SVC, K2);
    wait_edges(7);
    bus_read(A_CNT, rd);   check_eq("R5 prescaler restarted", rd, 32'd4);
    wait_edges(1);
    bus_read(A_CNT, rd);   check_eq("R5 first tick after reload", rd, 32'd3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule